// File: doc/BRIEF.md
# Processor Status Register with Condition Flags

This block holds the 16-bit status word of a small processor core. Each cycle it may take the outcome of one ALU operation, meaning the two operands, the result, the carry-out, an operation class and an operand size, and turn it into the carry, zero, negative and signed-overflow flags. The same word carries the interrupt-enable bit and four power-control bits. Software can overwrite these bits with a full move, or change them with a bit-set (OR) or bit-clear (AND-NOT) write.

The ALU report is a one-cycle strobe (`alu_valid`) that the block always accepts. There is no ready signal and no back-pressure, because the register absorbs one update per clock. A write on the software port in the same cycle takes precedence over the ALU report. Two signals are decoded from the stored word. The first is a maskable-interrupt enable. The second is a low-power request vector, which stays all-zero while the core-halt bit is clear.

Stored bit positions: 0 carry, 1 zero, 2 negative, 3 interrupt enable, 4 core halt, 5 oscillator off, 6 clock-generator control 0, 7 clock-generator control 1, 8 overflow, 15..9 reserved.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset `sr_q` is 0x0000, `irq_enable` is 0 and `lpm_req` is 0.
- R2: Bits 15..9 of `sr_q` always read 0, whatever is written.
- R3: For an ALU update, the sign bit is result bit 7, 15 or 19 for `alu_size` 00 (byte), 01 (word) or 10 (20-bit). Code 11 behaves as word. N (bit 2) takes that sign bit. Z (bit 1) is 1 exactly when the result bits up to and including the sign bit are all zero.
- R4: For an ALU update, C (bit 0) takes `alu_carry`.
- R5: For `alu_class` 01 (add), V (bit 8) is 1 exactly when both operands have the same sign and the result sign differs from it.
- R6: For `alu_class` 10 (subtract/compare, result = `alu_dst` − `alu_src`), V is 1 exactly when a non-negative destination minus a negative source gives a negative result, or a negative destination minus a non-negative source gives a non-negative result.
- R7: `alu_class` 00 (logic/move) leaves V unchanged. `alu_class` 11 (logic, overflow cleared) sets V to 0.
- R8: `wr_mode` 00 (move) with `wr_en` loads `wr_data` masked to bits 8..0.
- R9: `wr_mode` 01 ORs `wr_data` into the word. `wr_mode` 10 clears the bits that are 1 in `wr_data`.
- R10: A write with `wr_mode` 00, 01 or 10 in the same cycle as `alu_valid` wins and the ALU flags are discarded. `wr_mode` 11 is no write, so a concurrent ALU update still applies.
- R11: `irq_enable` equals bit 3 of `sr_q`.
- R12: `lpm_req` is {bit 7, bit 6, bit 5, 1} when bit 4 is 1, and 0000 otherwise.
- R13: With neither `alu_valid` nor `wr_en`, `sr_q` holds its value.
- R14: An ALU update never changes bits 7..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_valid | input | 1 | ALU outcome present this cycle |
| alu_class | input | 2 | 00 logic keep V, 01 add, 10 subtract/compare, 11 logic clear V |
| alu_size | input | 2 | 00 byte, 01 word, 10 20-bit, 11 word |
| alu_src | input | 20 | Source operand |
| alu_dst | input | 20 | Destination operand |
| alu_res | input | 20 | ALU result |
| alu_carry | input | 1 | ALU carry-out |
| wr_en | input | 1 | Software write strobe |
| wr_mode | input | 2 | 00 move, 01 set bits, 10 clear bits, 11 none |
| wr_data | input | 16 | Write value or bit mask |
| sr_q | output | 16 | Stored status word |
| irq_enable | output | 1 | Maskable interrupts allowed |
| lpm_req | output | 4 | Low-power request {clkgen1, clkgen0, osc off, halt} |

## Verification
On every cycle the assertions check several behaviours: the reserved bits stay zero, an idle cycle holds the word, an ALU update leaves the control bits alone and copies the carry, a logic class with V kept does not move V, a move or set write lands exactly, and the decoded interrupt-enable and sleep vector follow the word. The overflow rules for add and subtract at each operand size are checked by the bench scenarios and its reference model. So are the zero test that ignores result bits above the selected size, the collision between a write and an ALU report, and the no-write mode.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W    = 16;
  localparam int POS_C   = 0;
  localparam int POS_Z   = 1;
  localparam int POS_N   = 2;
  localparam int POS_GIE = 3;
  localparam int POS_HLT = 4;
  localparam int POS_OSC = 5;
  localparam int POS_CG0 = 6;
  localparam int POS_CG1 = 7;
  localparam int POS_V   = 8;
  localparam logic [SR_W-1:0] LIVE_MASK = 16'h01FF;

  typedef enum logic [1:0] {
    OPC_LOGIC    = 2'b00,
    OPC_ADD      = 2'b01,
    OPC_SUB      = 2'b10,
    OPC_LOGIC_CV = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_EXT  = 2'b10,
    SZ_ALT  = 2'b11
  } op_size_e;

  typedef enum logic [1:0] {
    WR_MOVE  = 2'b00,
    WR_SET   = 2'b01,
    WR_CLEAR = 2'b10,
    WR_NONE  = 2'b11
  } wr_mode_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic v_load;
  } alu_flags_t;
endpackage

// File: rtl/sr_flag_gen.sv
module sr_flag_gen
  import sr_pkg::*;
#(
  parameter int OPW = 20
) (
  input  logic [1:0]     size_sel,
  input  logic [1:0]     op_class,
  input  logic [OPW-1:0] src,
  input  logic [OPW-1:0] dst,
  input  logic [OPW-1:0] res,
  input  logic           carry,
  output alu_flags_t     flags
);
  localparam int BYTE_MSB = 7;
  localparam int WORD_MSB = 15;
  localparam int EXT_MSB  = OPW - 1;

  logic [OPW-1:0] mask_byte, mask_word, mask_sel;
  logic           s_src, s_dst, s_res;

  for (genvar i = 0; i < OPW; i++) begin : g_mask
    assign mask_byte[i] = (i <= BYTE_MSB);
    assign mask_word[i] = (i <= WORD_MSB);
  end

  always_comb begin
    unique case (op_size_e'(size_sel))
      SZ_BYTE: begin
        mask_sel = mask_byte;
        s_src = src[BYTE_MSB]; s_dst = dst[BYTE_MSB]; s_res = res[BYTE_MSB];
      end
      SZ_EXT: begin
        mask_sel = '1;
        s_src = src[EXT_MSB]; s_dst = dst[EXT_MSB]; s_res = res[EXT_MSB];
      end
      default: begin
        mask_sel = mask_word;
        s_src = src[WORD_MSB]; s_dst = dst[WORD_MSB]; s_res = res[WORD_MSB];
      end
    endcase
  end

  always_comb begin
    flags.c = carry;
    flags.n = s_res;
    flags.z = ((res & mask_sel) == '0);
    unique case (op_class_e'(op_class))
      OPC_ADD: begin
        flags.v      = (s_src == s_dst) && (s_res != s_dst);
        flags.v_load = 1'b1;
      end
      OPC_SUB: begin
        flags.v      = (s_src != s_dst) && (s_res != s_dst);
        flags.v_load = 1'b1;
      end
      OPC_LOGIC_CV: begin
        flags.v      = 1'b0;
        flags.v_load = 1'b1;
      end
      default: begin
        flags.v      = 1'b0;
        flags.v_load = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sr_next_state.sv
module sr_next_state
  import sr_pkg::*;
(
  input  logic [SR_W-1:0] cur,
  input  logic            alu_valid,
  input  alu_flags_t      flags,
  input  logic            wr_en,
  input  logic [1:0]      wr_mode,
  input  logic [SR_W-1:0] wr_data,
  output logic [SR_W-1:0] nxt
);
  logic            sw_write;
  logic [SR_W-1:0] sw_val, alu_val;

  assign sw_write = wr_en && (wr_mode_e'(wr_mode) != WR_NONE);

  always_comb begin
    unique case (wr_mode_e'(wr_mode))
      WR_MOVE:  sw_val = wr_data;
      WR_SET:   sw_val = cur | wr_data;
      WR_CLEAR: sw_val = cur & ~wr_data;
      default:  sw_val = cur;
    endcase
  end

  always_comb begin
    alu_val        = cur;
    alu_val[POS_C] = flags.c;
    alu_val[POS_Z] = flags.z;
    alu_val[POS_N] = flags.n;
    if (flags.v_load) alu_val[POS_V] = flags.v;
  end

  always_comb begin
    if (sw_write)       nxt = sw_val & LIVE_MASK;
    else if (alu_valid) nxt = alu_val & LIVE_MASK;
    else                nxt = cur;
  end
endmodule

// File: rtl/sr_power_decode.sv
module sr_power_decode
  import sr_pkg::*;
(
  input  logic [SR_W-1:0] sr,
  output logic            irq_enable,
  output logic [3:0]      lpm_req
);
  assign irq_enable = sr[POS_GIE];
  assign lpm_req    = sr[POS_HLT] ? {sr[POS_CG1], sr[POS_CG0], sr[POS_OSC], 1'b1} : 4'b0000;
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import sr_pkg::*;
#(
  parameter int OPW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alu_valid,
  input  logic [1:0]      alu_class,
  input  logic [1:0]      alu_size,
  input  logic [OPW-1:0]  alu_src,
  input  logic [OPW-1:0]  alu_dst,
  input  logic [OPW-1:0]  alu_res,
  input  logic            alu_carry,
  input  logic            wr_en,
  input  logic [1:0]      wr_mode,
  input  logic [15:0]     wr_data,
  output logic [15:0]     sr_q,
  output logic            irq_enable,
  output logic [3:0]      lpm_req
);
  alu_flags_t      flags;
  logic [SR_W-1:0] sr_nxt;
  logic            alu_only;

  sr_flag_gen #(.OPW(OPW)) u_flags (
    .size_sel (alu_size),
    .op_class (alu_class),
    .src      (alu_src),
    .dst      (alu_dst),
    .res      (alu_res),
    .carry    (alu_carry),
    .flags    (flags)
  );

  sr_next_state u_next (
    .cur       (sr_q),
    .alu_valid (alu_valid),
    .flags     (flags),
    .wr_en     (wr_en),
    .wr_mode   (wr_mode),
    .wr_data   (wr_data),
    .nxt       (sr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  sr_power_decode u_pwr (
    .sr         (sr_q),
    .irq_enable (irq_enable),
    .lpm_req    (lpm_req)
  );

  assign alu_only = alu_valid && !(wr_en && wr_mode != 2'b11);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[15:9] == 7'd0);
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_valid && !wr_en) |=> $stable(sr_q));
  a_r14_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    alu_only |=> $stable(sr_q[7:3]));
  a_r4_carry_copy: assert property (@(posedge clk) disable iff (!rst_n)
    alu_only |=> sr_q[0] == $past(alu_carry));
  a_r7_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_only && alu_class == 2'b00) |=> $stable(sr_q[8]));
  a_r8_move_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == 2'b00) |=> sr_q == ($past(wr_data) & 16'h01FF));
  a_r9_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == 2'b01) |=> (sr_q & $past(wr_data) & 16'h01FF) == ($past(wr_data) & 16'h01FF));
  a_r11_gie_follow: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enable == sr_q[3]);
  a_r12_awake_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_q[4] |-> lpm_req == 4'b0000);
endmodule

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_valid = 1'b0;
  logic [1:0]  alu_class = 2'b00, alu_size = 2'b00, wr_mode = 2'b11;
  logic [19:0] alu_src = '0, alu_dst = '0, alu_res = '0;
  logic        alu_carry = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] sr_q;
  logic        irq_enable;
  logic [3:0]  lpm_req;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  int model_sr = 0;

  always #4 clk = ~clk;

  cpu_status_reg uut (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_class(alu_class),
    .alu_size(alu_size), .alu_src(alu_src), .alu_dst(alu_dst), .alu_res(alu_res),
    .alu_carry(alu_carry), .wr_en(wr_en), .wr_mode(wr_mode), .wr_data(wr_data),
    .sr_q(sr_q), .irq_enable(irq_enable), .lpm_req(lpm_req)
  );

  function automatic int model_next(int cur);
    int msb, nv, v;
    bit sa, sd, sr;
    longint mask;
    nv = cur;
    if (wr_en && wr_mode != 2'b11) begin
      if (wr_mode == 2'b00)      nv = wr_data;
      else if (wr_mode == 2'b01) nv = cur | wr_data;
      else                       nv = cur & ~int'(wr_data);
      return nv & 'h1FF;
    end
    if (!alu_valid) return cur;
    msb  = (alu_size == 2'b00) ? 7 : (alu_size == 2'b10) ? 19 : 15;
    mask = (64'd1 << (msb + 1)) - 1;
    sa = alu_src[msb]; sd = alu_dst[msb]; sr = alu_res[msb];
    nv = nv & ~'h107;
    if (alu_carry) nv = nv | 1;
    if ((alu_res & mask) == 0) nv = nv | 2;
    if (sr) nv = nv | 4;
    v = (cur >> 8) & 1;
    case (alu_class)
      2'b01: v = ((!sa && !sd && sr) || (sa && sd && !sr)) ? 1 : 0;
      2'b10: v = ((!sd && sa && sr) || (sd && !sa && !sr)) ? 1 : 0;
      2'b11: v = 0;
      default: ;
    endcase
    if (v != 0) nv = nv | 'h100;
    return nv & 'h1FF;
  endfunction

  task automatic compare(string tag);
    logic [3:0] exp_lpm;
    exp_lpm = model_sr[4] ? {model_sr[7], model_sr[6], model_sr[5], 1'b1} : 4'b0000;
    vectors++;
    if (sr_q !== model_sr[15:0]) begin
      miscompares++;
      $display("FAIL %s sr_q actual=%h expected=%h", tag, sr_q, model_sr[15:0]);
    end
    if (irq_enable !== model_sr[3]) begin
      miscompares++;
      $display("FAIL %s irq_enable actual=%b expected=%b", tag, irq_enable, model_sr[3]);
    end
    if (lpm_req !== exp_lpm) begin
      miscompares++;
      $display("FAIL %s lpm_req actual=%b expected=%b", tag, lpm_req, exp_lpm);
    end
  endtask

  task automatic step(string tag, bit av, logic [1:0] cls, logic [1:0] sz,
                      logic [19:0] a, logic [19:0] d, logic [19:0] r, bit cy,
                      bit we, logic [1:0] wm, logic [15:0] wd);
    @(negedge clk);
    alu_valid = av; alu_class = cls; alu_size = sz;
    alu_src = a; alu_dst = d; alu_res = r; alu_carry = cy;
    wr_en = we; wr_mode = wm; wr_data = wd;
    @(posedge clk);
    model_sr = model_next(model_sr);
    #2;
    compare(tag);
  endtask

  task automatic alu(string tag, logic [1:0] cls, logic [1:0] sz,
                     logic [19:0] a, logic [19:0] d, logic [19:0] r, bit cy);
    step(tag, 1, cls, sz, a, d, r, cy, 0, 2'b11, 16'h0);
  endtask

  task automatic wr(string tag, logic [1:0] wm, logic [15:0] wd);
    step(tag, 0, 2'b00, 2'b01, 20'h0, 20'h0, 20'h0, 0, 1, wm, wd);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    model_sr = 0;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R5 add overflow at each size, R3 sign and zero selection
    alu("R5 byte pos+pos", 2'b01, 2'b00, 20'h00070, 20'h00010, 20'h00080, 0);
    alu("R5 byte neg+neg", 2'b01, 2'b00, 20'h00080, 20'h00080, 20'h00100, 1);
    alu("R5 word pos+pos", 2'b01, 2'b01, 20'h00001, 20'h07FFF, 20'h08000, 0);
    alu("R5 word no ovf", 2'b01, 2'b01, 20'h0FFFF, 20'h00001, 20'h10000, 1);
    alu("R5 ext pos+pos", 2'b01, 2'b10, 20'h00001, 20'h7FFFF, 20'h80000, 0);
    alu("R3 byte zero ignores upper", 2'b01, 2'b00, 20'h00001, 20'h000FF, 20'hFFF00, 1);
    alu("R3 size 11 as word", 2'b01, 2'b11, 20'h00000, 20'h08000, 20'h08000, 0);
    alu("R3 ext zero", 2'b00, 2'b10, 20'h0, 20'h0, 20'h00000, 0);
    // R6 subtract/compare overflow
    alu("R6 pos-neg=neg", 2'b10, 2'b01, 20'h0FFFF, 20'h07FFF, 20'h08000, 0);
    alu("R6 neg-pos=pos", 2'b10, 2'b01, 20'h00001, 20'h08000, 20'h07FFF, 1);
    alu("R6 no ovf", 2'b10, 2'b01, 20'h00003, 20'h00005, 20'h00002, 1);
    alu("R6 byte neg-pos", 2'b10, 2'b00, 20'h00001, 20'h00080, 20'h0007F, 1);
    // R7 logic classes
    alu("R7 logic keeps V", 2'b00, 2'b01, 20'h0, 20'h0, 20'h00012, 0);
    alu("R7 logic clears V", 2'b11, 2'b01, 20'h0, 20'h0, 20'h00012, 1);
    alu("R4 carry clear", 2'b00, 2'b01, 20'h0, 20'h0, 20'h00001, 0);
    // R8, R2, R11, R12 writes
    wr("R8 move all ones R2", 2'b00, 16'hFFFF);
    wr("R12 clear osc", 2'b10, 16'h0020);
    wr("R9 clear halt R12", 2'b10, 16'h0010);
    wr("R9 clear gie R11", 2'b10, 16'h0008);
    wr("R9 set gie R11", 2'b01, 16'h0008);
    wr("R9 set halt reserved R2", 2'b01, 16'hFE10);
    // R14 ALU leaves control bits
    alu("R14 alu keeps ctrl", 2'b01, 2'b01, 20'h00001, 20'h00001, 20'h00002, 0);
    // R10 priority and no-write mode
    step("R10 write wins", 1, 2'b01, 2'b00, 20'h70, 20'h10, 20'h80, 1, 1, 2'b00, 16'h0048);
    step("R10 mode 11 lets alu", 1, 2'b01, 2'b00, 20'h70, 20'h10, 20'h80, 1, 1, 2'b11, 16'hFFFF);
    step("R10 set wins", 1, 2'b11, 2'b00, 20'h0, 20'h0, 20'h0, 0, 1, 2'b01, 16'h00D0);
    // R13 idle
    step("R13 idle hold", 0, 2'b11, 2'b00, 20'h0, 20'h0, 20'h0, 1, 0, 2'b00, 16'h0000);
    step("R13 idle hold 2", 0, 2'b01, 2'b10, 20'hFFFFF, 20'hFFFFF, 20'h0, 0, 0, 2'b10, 16'hFFFF);

    for (int i = 0; i < 400; i++) begin
      step("RND", ($urandom % 3) != 0, 2'($urandom), 2'($urandom),
           20'($urandom), 20'($urandom), 20'(($urandom % 4 == 0) ? 0 : $urandom), 1'($urandom),
           ($urandom % 4) == 0, 2'($urandom), 16'($urandom));
    end
    summary();
  end
endmodule